// File: doc/BRIEF.md
# Receive Port Statistics Counter Bank

This block keeps a bank of saturating event counters for a single receive port. Once per accepted frame, an upstream parser presents a one-cycle status record. The record carries the frame length in bytes, an interface-error flag, an FCS-error flag, a drop mark, a destination class (unicast, multicast or broadcast) and a parse mode. From that record the block decides which counters move in the same clock edge. Processed and dropped traffic are tallied apart. Frame sizes go into a fixed histogram. Undersized and oversized frames are split by FCS status. Multicast and broadcast are counted only for frames parsed from layer 2 onward.

Software reads one counter at a time through a small register port: it presents an index with a read strobe and gets the value one cycle later. A read-clear flag presented with the strobe zeroes the addressed counter as it is read. An event that arrives in the same cycle is kept and lands on the freshly zeroed value. Counters stop at all-ones rather than wrapping.

Top module: `rx_port_stats`

## Requirements
- R1: A valid record with the drop mark low adds 1 to the processed-packet counter and its length to the processed-octet counter. With the drop mark high, it adds 1 to the dropped-packet counter and its length to the dropped-octet counter instead, and leaves the processed counters unchanged.
- R2: The error-packet counter adds 1 for every valid record whose interface-error flag is high, whatever its other fields.
- R3: A record whose length lies between 64 and MAX_LEN bytes adds 1 to exactly one histogram bin. The bins are 64, 65-127, 128-255, 256-511, 512-1023, 1024-1518 and 1519-MAX_LEN. Lengths below 64 or above MAX_LEN touch no bin.
- R4: A record shorter than 64 bytes adds 1 to the runt counter when its FCS-error flag is low, and to the runt-with-FCS-error counter when it is high.
- R5: A record longer than MAX_LEN bytes adds 1 to the oversize counter when its FCS-error flag is low, and to the oversize-with-FCS-error counter when it is high.
- R6: Destination class 2'b01 is multicast, 2'b10 is broadcast, and 2'b00 and 2'b11 are neither. The multicast and broadcast counters move only when the parse mode equals 2'b01 (layer-2 parse); any other mode leaves both unchanged.
- R7: When rd_en is high at a clock edge, the next cycle shows rd_valid high and rd_data holding the addressed counter's value from before that edge. When rd_en is low, rd_valid is low. An index of 18 or more returns zero. The index map is: 0 processed packets, 1 processed octets, 2 dropped packets, 3 dropped octets, 4 multicast, 5 broadcast, 6 to 12 histogram bins in ascending size, 13 runt, 14 runt with FCS error, 15 oversize, 16 oversize with FCS error, 17 error packets.
- R8: A read with rd_clr high returns the counter's value and leaves that counter at zero. Other counters are untouched.
- R9: If a clearing read and an increment of the same counter fall in the same cycle, the read returns the old value and the counter then holds just that cycle's increment.
- R10: Each counter saturates at all-ones (2^CW-1) and never wraps.
- R11: After a synchronous active-low reset, every counter reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rec_valid | input | 1 | Status record present this cycle |
| rec_len | input | LEN_W | Frame length in bytes |
| rec_err | input | 1 | Interface error seen on the frame |
| rec_fcs_err | input | 1 | FCS check failed |
| rec_drop | input | 1 | Frame marked to be dropped |
| rec_dest | input | 2 | Destination class: 01 multicast, 10 broadcast |
| rec_mode | input | 2 | Parse mode; 01 means parsed from layer 2 |
| rd_en | input | 1 | Read strobe |
| rd_idx | input | 5 | Counter index |
| rd_clr | input | 1 | Zero the addressed counter as it is read |
| rd_data | output | CW | Value read |
| rd_valid | output | 1 | rd_data is valid this cycle |

## Verification
The hardest states to reach from the ports are saturation and a clearing read that collides with an increment. With 32-bit counters, saturation is out of reach in a short run. The bench therefore builds the block with 16-bit counters and sends 1500-byte frames until the octet counter passes 65535, then checks that it sticks at all-ones after another frame. For the collision, the bench drives a record and a clearing read of the octet counter on the same edge. It expects the old total back, then exactly the new frame's length on the next read.

// File: rtl/rxs_pkg.sv
// Shared constants for the receive statistics bank: counter indices and
// field encodings. Assumes counter order is fixed by software's index map.
package rxs_pkg;
    localparam int NUM_CTR   = 18;
    localparam int CTR_IDX_W = $clog2(NUM_CTR);

    localparam int CTR_PKTS      = 0;
    localparam int CTR_OCTS      = 1;
    localparam int CTR_DROP_PKTS = 2;
    localparam int CTR_DROP_OCTS = 3;
    localparam int CTR_MCAST     = 4;
    localparam int CTR_BCAST     = 5;
    localparam int CTR_HIST0     = 6;   // 64
    localparam int CTR_HIST1     = 7;   // 65-127
    localparam int CTR_HIST2     = 8;   // 128-255
    localparam int CTR_HIST3     = 9;   // 256-511
    localparam int CTR_HIST4     = 10;  // 512-1023
    localparam int CTR_HIST5     = 11;  // 1024-1518
    localparam int CTR_HIST6     = 12;  // 1519-max
    localparam int CTR_RUNT      = 13;
    localparam int CTR_RUNT_FCS  = 14;
    localparam int CTR_OVER      = 15;
    localparam int CTR_OVER_FCS  = 16;
    localparam int CTR_ERR_PKTS  = 17;

    localparam logic [1:0] DEST_MCAST = 2'b01;
    localparam logic [1:0] DEST_BCAST = 2'b10;
    localparam logic [1:0] MODE_L2    = 2'b01;

    localparam int RUNT_LIMIT = 64;
endpackage

// File: rtl/rxs_classify.sv
// Decodes one per-frame status record into a vector of counter strobes.
// Purely combinational; clk/rst_n serve only the local assertions.
// Assumes MAX_LEN >= 1519 and that MAX_LEN fits in LEN_W bits.
module rxs_classify
    import rxs_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int MAX_LEN = 1536
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vld,
    input  logic [LEN_W-1:0]   len,
    input  logic               err,
    input  logic               fcs_err,
    input  logic               drop,
    input  logic [1:0]         dest,
    input  logic [1:0]         mode,
    output logic [NUM_CTR-1:0] ev
);
    localparam logic [LEN_W-1:0] L_MIN  = LEN_W'(RUNT_LIMIT);
    localparam logic [LEN_W-1:0] L_127  = LEN_W'(127);
    localparam logic [LEN_W-1:0] L_255  = LEN_W'(255);
    localparam logic [LEN_W-1:0] L_511  = LEN_W'(511);
    localparam logic [LEN_W-1:0] L_1023 = LEN_W'(1023);
    localparam logic [LEN_W-1:0] L_1518 = LEN_W'(1518);
    localparam logic [LEN_W-1:0] L_MAX  = LEN_W'(MAX_LEN);

    logic [6:0] hist;

    // Pick the one histogram bin a length in range belongs to.
    always_comb begin
        hist = '0;
        if (len < L_MIN || len > L_MAX) hist = '0;
        else if (len == L_MIN)          hist[0] = 1'b1;
        else if (len <= L_127)          hist[1] = 1'b1;
        else if (len <= L_255)          hist[2] = 1'b1;
        else if (len <= L_511)          hist[3] = 1'b1;
        else if (len <= L_1023)         hist[4] = 1'b1;
        else if (len <= L_1518)         hist[5] = 1'b1;
        else                            hist[6] = 1'b1;
    end

    // Build the strobe vector for all counters from the record.
    always_comb begin
        ev = '0;
        if (vld) begin
            if (drop) begin
                ev[CTR_DROP_PKTS] = 1'b1;
                ev[CTR_DROP_OCTS] = 1'b1;
            end else begin
                ev[CTR_PKTS] = 1'b1;
                ev[CTR_OCTS] = 1'b1;
            end
            ev[CTR_ERR_PKTS] = err;
            if (mode == MODE_L2) begin
                ev[CTR_MCAST] = (dest == DEST_MCAST);
                ev[CTR_BCAST] = (dest == DEST_BCAST);
            end
            if (len < L_MIN) begin
                ev[CTR_RUNT]     = !fcs_err;
                ev[CTR_RUNT_FCS] = fcs_err;
            end
            if (len > L_MAX) begin
                ev[CTR_OVER]     = !fcs_err;
                ev[CTR_OVER_FCS] = fcs_err;
            end
            ev[CTR_HIST6:CTR_HIST0] = hist;
        end
    end

    AST_CAST_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev[CTR_MCAST] && ev[CTR_BCAST])); // R6
    AST_HIST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ev[CTR_HIST6:CTR_HIST0])); // R3
    AST_RUNT_NO_BIN: assert property (@(posedge clk) disable iff (!rst_n)
        (ev[CTR_RUNT] || ev[CTR_RUNT_FCS] || ev[CTR_OVER] || ev[CTR_OVER_FCS])
        |-> (ev[CTR_HIST6:CTR_HIST0] == '0)); // R4
    AST_DROP_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev[CTR_PKTS] && ev[CTR_DROP_PKTS])); // R1
endmodule

// File: rtl/rxs_counter.sv
// One saturating counter with a same-cycle clear. A clear zeroes the base
// value before the increment is added, so a colliding event is kept.
// Assumes AW <= CW.
module rxs_counter #(
    parameter int CW = 32,
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic [AW-1:0] amt,
    input  logic          clr,
    output logic [CW-1:0] val
);
    logic [CW-1:0] base;
    logic [CW:0]   sum;
    logic [CW-1:0] nxt;

    // Form the next value: cleared or kept base plus amount, capped at all-ones.
    always_comb begin
        base = clr ? '0 : val;
        sum  = {1'b0, base} + (inc ? (CW+1)'(amt) : '0);
        nxt  = sum[CW] ? '1 : sum[CW-1:0];
    end

    // Hold the count.
    always_ff @(posedge clk) begin
        if (!rst_n) val <= '0;
        else        val <= nxt;
    end

    AST_SAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (val == '1 && !clr) |=> (val == '1)); // R10
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (val >= $past(val))); // R10
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !inc) |=> (val == '0)); // R8
    AST_CLR_KEEP_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && inc) |=> (val == CW'($past(amt)))); // R9
endmodule

// File: rtl/rx_port_stats.sv
// Statistics bank for one receive port: a classifier turns each status record
// into counter strobes, a generated array of saturating counters holds the
// totals, and a registered read port returns one counter per request with an
// optional clear. Assumes CW >= LEN_W and MAX_LEN >= 1519.
module rx_port_stats
    import rxs_pkg::*;
#(
    parameter int CW      = 32,
    parameter int LEN_W   = 16,
    parameter int MAX_LEN = 1536
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rec_valid,
    input  logic [LEN_W-1:0]     rec_len,
    input  logic                 rec_err,
    input  logic                 rec_fcs_err,
    input  logic                 rec_drop,
    input  logic [1:0]           rec_dest,
    input  logic [1:0]           rec_mode,
    input  logic                 rd_en,
    input  logic [CTR_IDX_W-1:0] rd_idx,
    input  logic                 rd_clr,
    output logic [CW-1:0]        rd_data,
    output logic                 rd_valid
);
    logic [NUM_CTR-1:0] ev;
    logic [NUM_CTR-1:0] clr_vec;
    logic [CW-1:0]      vals [NUM_CTR];
    logic [CW-1:0]      rd_mux;

    rxs_classify #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_cls (
        .clk(clk), .rst_n(rst_n), .vld(rec_valid), .len(rec_len),
        .err(rec_err), .fcs_err(rec_fcs_err), .drop(rec_drop),
        .dest(rec_dest), .mode(rec_mode), .ev(ev)
    );

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        localparam bit IS_OCT = (i == CTR_OCTS) || (i == CTR_DROP_OCTS);
        logic [LEN_W-1:0] amt;
        // Octet counters add the frame length, all others add one.
        always_comb amt = IS_OCT ? rec_len : LEN_W'(1);
        // Clear this counter when a clearing read addresses it.
        always_comb clr_vec[i] = rd_en && rd_clr && (rd_idx == CTR_IDX_W'(i));
        rxs_counter #(.CW(CW), .AW(LEN_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .inc(ev[i]), .amt(amt),
            .clr(clr_vec[i]), .val(vals[i])
        );
    end

    // Select the addressed counter; unknown indices read as zero.
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_CTR; i++)
            if (rd_idx == CTR_IDX_W'(i)) rd_mux = vals[i];
    end

    // Register the read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= rd_mux;
        end
    end

    AST_RD_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid); // R7
    AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid); // R7
    AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_vec)); // R8
endmodule

// File: tb/tb_rx_port_stats.sv
module tb_rx_port_stats;
    localparam int CLK_PERIOD = 10;
    localparam int CW      = 16;
    localparam int LEN_W   = 16;
    localparam int MAX_LEN = 1536;
    localparam int NC      = 18;
    localparam longint MAXV = (64'd1 << CW) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rec_valid = 1'b0;
    logic [LEN_W-1:0] rec_len = '0;
    logic             rec_err = 1'b0, rec_fcs_err = 1'b0, rec_drop = 1'b0;
    logic [1:0]       rec_dest = 2'b00, rec_mode = 2'b00;
    logic             rd_en = 1'b0, rd_clr = 1'b0;
    logic [4:0]       rd_idx = '0;
    logic [CW-1:0]    rd_data;
    logic             rd_valid;

    int n_chk = 0, n_fail = 0;
    longint model [NC];

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_port_stats #(.CW(CW), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) dut (
        .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_len(rec_len),
        .rec_err(rec_err), .rec_fcs_err(rec_fcs_err), .rec_drop(rec_drop),
        .rec_dest(rec_dest), .rec_mode(rec_mode), .rd_en(rd_en),
        .rd_idx(rd_idx), .rd_clr(rd_clr), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    function automatic string req_of(int i);
        if (i <= 3)  return "R1";
        if (i <= 5)  return "R6";
        if (i <= 12) return "R3";
        if (i <= 14) return "R4";
        if (i <= 16) return "R5";
        if (i == 17) return "R2";
        return "R7";
    endfunction

    function automatic longint sat(longint v, longint a);
        return (v + a > MAXV) ? MAXV : v + a;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Expected counter effects of one record, from the requirements.
    task automatic model_rec(int len, bit e, bit f, bit d, logic [1:0] dst, logic [1:0] md);
        if (d) begin model[2] = sat(model[2], 1); model[3] = sat(model[3], len); end
        else   begin model[0] = sat(model[0], 1); model[1] = sat(model[1], len); end
        if (e) model[17] = sat(model[17], 1);
        if (md == 2'b01 && dst == 2'b01) model[4] = sat(model[4], 1);
        if (md == 2'b01 && dst == 2'b10) model[5] = sat(model[5], 1);
        if (len < 64) begin
            if (f) model[14] = sat(model[14], 1); else model[13] = sat(model[13], 1);
        end else if (len > MAX_LEN) begin
            if (f) model[16] = sat(model[16], 1); else model[15] = sat(model[15], 1);
        end else begin
            int b;
            if (len == 64) b = 6; else if (len <= 127) b = 7; else if (len <= 255) b = 8;
            else if (len <= 511) b = 9; else if (len <= 1023) b = 10;
            else if (len <= 1518) b = 11; else b = 12;
            model[b] = sat(model[b], 1);
        end
    endtask

    // One cycle of stimulus: optional record and optional read, then check.
    task automatic step(bit dv, int len, bit e, bit f, bit d, logic [1:0] dst,
                        logic [1:0] md, bit dr, int idx, bit cl, string tag);
        longint expd = 0;
        @(negedge clk);
        rec_valid = dv; rec_len = LEN_W'(len); rec_err = e; rec_fcs_err = f;
        rec_drop = d; rec_dest = dst; rec_mode = md;
        rd_en = dr; rd_idx = 5'(idx); rd_clr = cl;
        if (dr) begin
            expd = (idx < NC) ? model[idx] : 0;
            if (cl && idx < NC) model[idx] = 0;
        end
        if (dv) model_rec(len, e, f, d, dst, md);
        @(negedge clk);
        rec_valid = 1'b0; rd_en = 1'b0; rd_clr = 1'b0;
        if (dr) chk(rd_valid && (longint'(rd_data) == expd), tag, longint'(rd_data), expd);
    endtask

    task automatic send(int len, bit e, bit f, bit d, logic [1:0] dst, logic [1:0] md);
        step(1, len, e, f, d, dst, md, 0, 0, 0, "");
    endtask

    task automatic rd(int idx, bit cl, string tag);
        step(0, 0, 0, 0, 0, 2'b00, 2'b00, 1, idx, cl, tag);
    endtask

    task automatic check_all(string suffix);
        for (int i = 0; i < NC; i++) rd(i, 0, {req_of(i), suffix});
    endtask

    task automatic clear_all();
        for (int i = 0; i < NC; i++) rd(i, 1, "R8 clear sweep");
    endtask

    task automatic t_reset();
        for (int i = 0; i < NC; i++) model[i] = 0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NC; i++) rd(i, 0, "R11 reset value");
    endtask

    task automatic t_traffic();
        int lens [13] = '{64, 65, 127, 128, 255, 256, 511, 512, 1023, 1024, 1518, 1519, 1536};
        foreach (lens[k]) send(lens[k], 0, 0, 0, 2'b00, 2'b00);
        send(40, 0, 0, 0, 2'b00, 2'b00);     // runt, good FCS
        send(63, 0, 1, 0, 2'b00, 2'b00);     // runt, bad FCS
        send(1537, 0, 0, 0, 2'b00, 2'b00);   // oversize, good FCS
        send(2000, 0, 1, 0, 2'b00, 2'b00);   // oversize, bad FCS
        send(100, 0, 0, 1, 2'b00, 2'b00);    // dropped
        send(700, 0, 0, 1, 2'b01, 2'b01);    // dropped multicast
        send(80, 1, 0, 0, 2'b00, 2'b00);     // interface error
        send(90, 0, 0, 0, 2'b01, 2'b01);     // multicast, L2
        send(90, 0, 0, 0, 2'b10, 2'b01);     // broadcast, L2
        send(90, 0, 0, 0, 2'b01, 2'b00);     // multicast, other mode: ignored
        send(90, 0, 0, 0, 2'b10, 2'b10);     // broadcast, other mode: ignored
        send(90, 0, 0, 0, 2'b11, 2'b01);     // class 11: neither
        check_all(" mixed traffic");
    endtask

    task automatic t_read_port();
        rd(20, 0, "R7 out-of-range index");
        @(negedge clk);
        chk(rd_valid == 1'b0, "R7 rd_valid idle", rd_valid, 0);
    endtask

    task automatic t_read_clear();
        rd(1, 1, "R8 clearing read returns value");
        rd(1, 0, "R8 counter zero after clear");
        rd(0, 0, "R8 neighbour untouched");
        clear_all();
    endtask

    task automatic t_collision();
        repeat (3) send(100, 0, 0, 0, 2'b00, 2'b00);
        step(1, 200, 0, 0, 0, 2'b00, 2'b00, 1, 1, 1, "R9 collision returns old total");
        rd(1, 0, "R9 collision keeps new event");
        rd(0, 0, "R9 packet counter unaffected");
        clear_all();
    endtask

    task automatic t_saturate();
        repeat (44) send(1500, 0, 0, 0, 2'b00, 2'b00);
        rd(1, 0, "R10 octets saturated");
        rd(0, 0, "R10 packets below limit");
        send(1500, 0, 0, 0, 2'b00, 2'b00);
        rd(1, 0, "R10 saturated stays all-ones");
        rd(1, 1, "R10 clear saturated");
        rd(1, 0, "R10 zero after clear");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_traffic();
        t_read_port();
        t_read_clear();
        t_collision();
        t_saturate();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule